// File: doc/BRIEF.md
# LCD Panel Power and Setup Sequencer

This block brings a small LCD panel up and down in a fixed order, and programs the panel's configuration registers over a write-only SPI link. Each register write is one 16-bit frame. A power-up request raises the panel supply and waits a timed settling interval. It then releases the panel's active-low reset and sends a fixed script of register writes, ending with the full gamma table. A power-down request parks the panel in standby around the reset. It then waits at least two frame times, sends a final standby write and drops the supply.

Between power cycles the host can change the scan mode, the horizontal and vertical mirroring and the twelve-entry, 10-bit gamma table. Each change writes only the panel registers it affects. Requests that arrive while a job is running are remembered and serviced afterwards. Millisecond delays are counted from a parameter giving clock cycles per millisecond.

Top module: `panel_seq`

## Requirements
- R1: Every SPI frame is 16 bits, sent MSB first. Bits 15:10 hold the 6-bit register address, bit 9 is 0, bit 8 is 1 and bits 7:0 hold the data byte.
- R2: After reset, supply_en, panel_rst_n, spi_sclk, busy and powered are low and spi_cs_n is high. The stored mode is 7, so the first power-up writes 0x0F to register 0x02.
- R3: On an accepted power-up, supply_en rises. panel_rst_n rises PWRUP_MS*CYC_PER_MS cycles later (up to two cycles of slack). No frame is sent before that.
- R4: After the reset release, the power-up script sends 20 frames in this order: reg 0x02 = 0x08|mode, reg 0x03 = 0xDF, reg 0x20 = 0xF0, reg 0x21 = 0xF0, reg 0x04 = mirror byte, then the 15 gamma frames. powered then rises.
- R5: The mirror byte is 0x17 with bit 0 cleared when horizontal mirroring is set, and bit 1 cleared when vertical mirroring is set.
- R6: The gamma frames are sent in this order. Regs 0x11, 0x12 and 0x13 each carry bits 9:8 of four consecutive entries, with the lowest entry in data bits 7:6 and the highest in bits 1:0. Regs 0x14..0x1F then carry the low bytes of entries 0..11 in turn. The defaults are 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023.
- R7: A power-down sends reg 0x03 = 0xD8 and then drives panel_rst_n low. It waits at least PWRDN_MS*CYC_PER_MS cycles, sends reg 0x03 = 0xD0, then lowers supply_en and powered.
- R8: A power-up request while powered, and a power-down request while unpowered, send no frame and change no output.
- R9: A mode request with mode_val at most 7 sends only reg 0x02 = 0x08|mode_val. A mode_val of 8 or more is dropped: nothing is sent and the stored mode is kept.
- R10: A mirror request sends only reg 0x04. A gamma apply sends only the 15 gamma frames. A gamma table write with gamma_idx of 12 or more changes no entry.
- R11: busy is high from the acceptance of a job until its last frame ends with spi_cs_n high. Requests that arrive meanwhile are serviced afterwards, in the priority order power-down, power-up, mode, mirror, gamma. Updates still pending once the panel is unpowered are dropped.
- R12: SPI mode 0: spi_sclk idles low while spi_cs_n is high, spi_mosi changes only while spi_sclk is low, and each frame has exactly 16 rising spi_sclk edges.
- R13: Mode, mirror and gamma changes made while unpowered send no frame. They are stored and used by the next power-up script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | One-cycle power-up request |
| pwr_off_req | input | 1 | One-cycle power-down request |
| mode_req | input | 1 | One-cycle mode change request |
| mode_val | input | 4 | Requested mode, values above 7 are rejected |
| mirror_req | input | 1 | One-cycle mirror change request |
| mirror_h | input | 1 | Horizontal mirroring wanted |
| mirror_v | input | 1 | Vertical mirroring wanted |
| gamma_wr | input | 1 | Write one gamma table entry |
| gamma_idx | input | 4 | Gamma entry index, 0..11 valid |
| gamma_val | input | 10 | Gamma entry value |
| gamma_apply | input | 1 | Request a rewrite of the gamma registers |
| supply_en | output | 1 | Panel supply enable |
| panel_rst_n | output | 1 | Active-low panel reset |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | A job is in progress |
| powered | output | 1 | Panel is fully powered up |

## Verification
A request is captured at the first clock edge and accepted at the next, so busy is high two edges after a request pulse. Frames are checked as whole words rather than cycle by cycle. The bench decodes spi_sclk and spi_mosi on the falling clock edge and compares each frame, when spi_cs_n rises, against a queue of expected words in order. The only cycle counts checked directly are the two long delays. For power-up, the gap from supply_en rising to panel_rst_n rising must be exactly the settling count, plus at most two cycles. For power-down, the gap from panel_rst_n falling to the next chip-select assertion must be the wait count plus at most three cycles, which covers the register hops between the timer and the SPI shifter.

// File: rtl/pnl_pkg.sv
package pnl_pkg;

  localparam int GAMMA_N = 12;
  localparam int GAMMA_W = 10;
  localparam int STEP_W  = 5;

  // script step numbers; the order is the order frames leave the block
  localparam logic [STEP_W-1:0] STEP_MODE   = 5'd0;
  localparam logic [STEP_W-1:0] STEP_MIRROR = 5'd4;
  localparam logic [STEP_W-1:0] STEP_GHI    = 5'd5;
  localparam logic [STEP_W-1:0] STEP_ON_END = 5'd19;
  localparam logic [STEP_W-1:0] STEP_STBY_A = 5'd20;
  localparam logic [STEP_W-1:0] STEP_STBY_B = 5'd21;

  typedef logic [GAMMA_N-1:0][GAMMA_W-1:0] gtab_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT_UP, SQ_SEND, SQ_WAIT_DN} sq_state_t;
  typedef enum logic [1:0] {JOB_ON, JOB_OFF_A, JOB_OFF_B, JOB_UPD} job_t;

  function automatic logic [15:0] spi_frame(input logic [5:0] addr, input logic [7:0] data);
    return {addr, 2'b01, data};
  endfunction

  function automatic logic [7:0] mirror_cfg(input logic h, input logic v);
    logic [7:0] r;
    r = 8'h17;
    if (h) r[0] = 1'b0;
    if (v) r[1] = 1'b0;
    return r;
  endfunction

  function automatic logic [GAMMA_W-1:0] gamma_default(input int i);
    case (i)
      0:       return 10'd105;
      1:       return 10'd315;
      2:       return 10'd381;
      3:       return 10'd431;
      4:       return 10'd490;
      5:       return 10'd537;
      6:       return 10'd579;
      7:       return 10'd686;
      8:       return 10'd780;
      9:       return 10'd837;
      10:      return 10'd880;
      default: return 10'd1023;
    endcase
  endfunction

  // top two bits of four entries, first entry in the highest pair
  function automatic logic [7:0] gamma_hi(input gtab_t t, input int grp);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) r[7-2*k -: 2] = t[grp*4+k][9:8];
    return r;
  endfunction

  function automatic logic [15:0] script_word(input logic [STEP_W-1:0] step, input logic [2:0] mode,
                                              input logic h, input logic v, input gtab_t t);
    int s;
    s = int'(step);
    case (step)
      5'd0:  return spi_frame(6'h02, {5'b00001, mode});
      5'd1:  return spi_frame(6'h03, 8'hDF);
      5'd2:  return spi_frame(6'h20, 8'hF0);
      5'd3:  return spi_frame(6'h21, 8'hF0);
      5'd4:  return spi_frame(6'h04, mirror_cfg(h, v));
      5'd20: return spi_frame(6'h03, 8'hD8);
      5'd21: return spi_frame(6'h03, 8'hD0);
      default: begin
        if (s >= 5 && s < 8)
          return spi_frame(6'(12 + s), gamma_hi(t, s - 5));
        else if (s >= 8 && s < 20)
          return spi_frame(6'(12 + s), t[s-8][7:0]);
        else
          return 16'h0000;
      end
    endcase
  endfunction

endpackage

// File: rtl/pnl_ms_timer.sv
module pnl_ms_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int MAX_MS     = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] ms,
  output logic       done
);
  localparam int CW = $clog2(CYC_PER_MS * MAX_MS + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign done = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= CW'(int'(ms) * CYC_PER_MS - 1);
      run <= 1'b1;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pnl_spi_tx.sv
module pnl_spi_tx #(
  parameter int HALF_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] word,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic        done
);
  localparam int HCW = $clog2(HALF_CYC) + 1;
  localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_CYC - 1);

  logic [15:0]    shreg;
  logic [HCW-1:0] half_cnt;
  logic [3:0]     bit_cnt;
  logic           active;

  assign mosi = !cs_n && shreg[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      half_cnt <= '0;
      bit_cnt  <= '0;
      active   <= 1'b0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        cs_n     <= 1'b0;
        shreg    <= word;
        sclk     <= 1'b0;
        half_cnt <= '0;
        bit_cnt  <= '0;
      end else if (active) begin
        if (half_cnt == HALF_LAST) begin
          half_cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == 4'd15) begin
              active <= 1'b0;
              cs_n   <= 1'b1;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= {shreg[14:0], 1'b0};
            end
          end
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pnl_gamma_store.sv
module pnl_gamma_store
  import pnl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_idx,
  input  logic [GAMMA_W-1:0] wr_data,
  output gtab_t              tab
);
  for (genvar g = 0; g < GAMMA_N; g++) begin : g_entry
    logic [GAMMA_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val_q <= gamma_default(g);
      else if (wr_en && (wr_idx == 4'(g)))
        val_q <= wr_data;
    end
    assign tab[g] = val_q;
  end
endmodule

// File: rtl/panel_seq.sv
module panel_seq
  import pnl_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int SCLK_HALF  = 4,
  parameter int PWRUP_MS   = 160,
  parameter int PWRDN_MS   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       pwr_off_req,
  input  logic       mode_req,
  input  logic [3:0] mode_val,
  input  logic       mirror_req,
  input  logic       mirror_h,
  input  logic       mirror_v,
  input  logic       gamma_wr,
  input  logic [3:0] gamma_idx,
  input  logic [9:0] gamma_val,
  input  logic       gamma_apply,
  output logic       supply_en,
  output logic       panel_rst_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n,
  output logic       busy,
  output logic       powered
);
  localparam int MAX_MS = (PWRUP_MS > PWRDN_MS) ? PWRUP_MS : PWRDN_MS;

  sq_state_t         state;
  job_t              job;
  logic [STEP_W-1:0] step, step_end;
  logic              issued;
  logic              supply_q, prst_q, powered_q;
  logic              pend_on, pend_off, pend_mode, pend_mir, pend_gam;
  logic [2:0]        mode_q;
  logic              mir_h_q, mir_v_q;
  gtab_t             gtab;

  // named internal events
  logic        in_idle, go_off, go_on, go_mode, go_mir, go_gam, evt_accept;
  logic        spi_start, spi_done, tmr_start, tmr_done, last_step, mode_ok;
  logic [7:0]  tmr_ms;
  logic [15:0] spi_word;

  assign in_idle    = (state == SQ_IDLE);
  assign go_off     = in_idle && pend_off && powered_q;
  assign go_on      = in_idle && pend_on && !powered_q && !go_off;
  assign go_mode    = in_idle && powered_q && !pend_off && pend_mode;
  assign go_mir     = in_idle && powered_q && !pend_off && !pend_mode && pend_mir;
  assign go_gam     = in_idle && powered_q && !pend_off && !pend_mode && !pend_mir && pend_gam;
  assign evt_accept = go_off || go_on || go_mode || go_mir || go_gam;
  assign mode_ok    = mode_req && !mode_val[3];

  assign last_step = (step == step_end);
  assign spi_start = (state == SQ_SEND) && !issued;
  assign spi_word  = script_word(step, mode_q, mir_h_q, mir_v_q, gtab);
  assign tmr_start = go_on || ((state == SQ_SEND) && spi_done && last_step && (job == JOB_OFF_A));
  assign tmr_ms    = go_on ? 8'(PWRUP_MS) : 8'(PWRDN_MS);

  assign supply_en   = supply_q;
  assign panel_rst_n = prst_q;
  assign powered     = powered_q;
  assign busy        = !in_idle;

  pnl_gamma_store u_gamma (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (gamma_wr),
    .wr_idx  (gamma_idx),
    .wr_data (gamma_val),
    .tab     (gtab)
  );

  pnl_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MAX_MS(MAX_MS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .ms    (tmr_ms),
    .done  (tmr_done)
  );

  pnl_spi_tx #(.HALF_CYC(SCLK_HALF)) u_spi (
    .clk   (clk),
    .rst_n (rst_n),
    .start (spi_start),
    .word  (spi_word),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .cs_n  (spi_cs_n),
    .done  (spi_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      job       <= JOB_UPD;
      step      <= '0;
      step_end  <= '0;
      issued    <= 1'b0;
      supply_q  <= 1'b0;
      prst_q    <= 1'b0;
      powered_q <= 1'b0;
      pend_on   <= 1'b0;
      pend_off  <= 1'b0;
      pend_mode <= 1'b0;
      pend_mir  <= 1'b0;
      pend_gam  <= 1'b0;
      mode_q    <= 3'd7;
      mir_h_q   <= 1'b0;
      mir_v_q   <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (go_off) begin
            job <= JOB_OFF_A; step <= STEP_STBY_A; step_end <= STEP_STBY_A;
            issued <= 1'b0; state <= SQ_SEND;
          end else if (go_on) begin
            supply_q <= 1'b1; state <= SQ_WAIT_UP;
          end else if (go_mode) begin
            job <= JOB_UPD; step <= STEP_MODE; step_end <= STEP_MODE;
            issued <= 1'b0; state <= SQ_SEND;
          end else if (go_mir) begin
            job <= JOB_UPD; step <= STEP_MIRROR; step_end <= STEP_MIRROR;
            issued <= 1'b0; state <= SQ_SEND;
          end else if (go_gam) begin
            job <= JOB_UPD; step <= STEP_GHI; step_end <= STEP_ON_END;
            issued <= 1'b0; state <= SQ_SEND;
          end
          // retire the chosen request and any that no longer apply
          if (go_off || !powered_q)  pend_off  <= 1'b0;
          if (go_on || powered_q)    pend_on   <= 1'b0;
          if (go_mode || !powered_q) pend_mode <= 1'b0;
          if (go_mir || !powered_q)  pend_mir  <= 1'b0;
          if (go_gam || !powered_q)  pend_gam  <= 1'b0;
        end
        SQ_WAIT_UP: begin
          if (tmr_done) begin
            prst_q <= 1'b1; job <= JOB_ON; step <= STEP_MODE; step_end <= STEP_ON_END;
            issued <= 1'b0; state <= SQ_SEND;
          end
        end
        SQ_SEND: begin
          if (spi_start) issued <= 1'b1;
          if (spi_done) begin
            if (last_step) begin
              case (job)
                JOB_ON: begin
                  powered_q <= 1'b1; state <= SQ_IDLE;
                end
                JOB_OFF_A: begin
                  prst_q <= 1'b0; state <= SQ_WAIT_DN;
                end
                JOB_OFF_B: begin
                  supply_q <= 1'b0; powered_q <= 1'b0; state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
              endcase
            end else begin
              step   <= step + 1'b1;
              issued <= 1'b0;
            end
          end
        end
        SQ_WAIT_DN: begin
          if (tmr_done) begin
            job <= JOB_OFF_B; step <= STEP_STBY_B; step_end <= STEP_STBY_B;
            issued <= 1'b0; state <= SQ_SEND;
          end
        end
        default: state <= SQ_IDLE;
      endcase
      // new requests win over retirement in the same cycle
      if (pwr_on_req)  pend_on  <= 1'b1;
      if (pwr_off_req) pend_off <= 1'b1;
      if (mode_ok) begin
        mode_q <= mode_val[2:0]; pend_mode <= 1'b1;
      end
      if (mirror_req) begin
        mir_h_q <= mirror_h; mir_v_q <= mirror_v; pend_mir <= 1'b1;
      end
      if (gamma_apply) pend_gam <= 1'b1;
    end
  end
endmodule

// File: rtl/panel_seq_checker.sv
module panel_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        supply_en,
  input logic        panel_rst_n,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        spi_cs_n,
  input logic        busy,
  input logic        powered,
  input logic        spi_start,
  input logic [15:0] spi_word,
  input logic        spi_done,
  input logic        evt_accept
);
  assert_reset_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_en |-> !panel_rst_n);

  assert_spi_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> supply_en);

  assert_frame_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> (spi_word[9:8] == 2'b01));

  assert_sclk_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_steady_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk) |-> $stable(spi_mosi));

  assert_done_releases_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_done |-> spi_cs_n);

  assert_cs_within_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  assert_accept_sets_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> busy);

  assert_powered_has_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    powered |-> supply_en);
endmodule

bind panel_seq panel_seq_checker u_panel_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_en   (supply_en),
  .panel_rst_n (panel_rst_n),
  .spi_sclk    (spi_sclk),
  .spi_mosi    (spi_mosi),
  .spi_cs_n    (spi_cs_n),
  .busy        (busy),
  .powered     (powered),
  .spi_start   (spi_start),
  .spi_word    (spi_word),
  .spi_done    (spi_done),
  .evt_accept  (evt_accept)
);

// File: tb/test_panel_seq.sv
`timescale 1ns/1ps
module test_panel_seq;
  localparam int CPM   = 10;
  localparam int HALF  = 2;
  localparam int UP_N  = 160 * CPM;
  localparam int DN_N  = 50 * CPM;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_on_req, pwr_off_req, mode_req, mirror_req, mirror_h, mirror_v;
  logic gamma_wr, gamma_apply;
  logic [3:0] mode_val, gamma_idx;
  logic [9:0] gamma_val;
  logic supply_en, panel_rst_n, spi_sclk, spi_mosi, spi_cs_n, busy, powered;

  always #2.5 clk = ~clk;

  panel_seq #(.CYC_PER_MS(CPM), .SCLK_HALF(HALF), .PWRUP_MS(160), .PWRDN_MS(50)) i_panel_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .mode_req(mode_req), .mode_val(mode_val), .mirror_req(mirror_req),
    .mirror_h(mirror_h), .mirror_v(mirror_v), .gamma_wr(gamma_wr), .gamma_idx(gamma_idx),
    .gamma_val(gamma_val), .gamma_apply(gamma_apply), .supply_en(supply_en),
    .panel_rst_n(panel_rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .busy(busy), .powered(powered));

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  // bench model of stored settings
  int b_mode = 7;
  bit b_h = 0, b_v = 0;
  int gm[12] = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bframe(input int a, input int d);
    return 16'(a * 1024 + 256 + (d % 256));
  endfunction

  function automatic int bmirror(input bit h, input bit v);
    return 23 - (h ? 1 : 0) - (v ? 2 : 0);
  endfunction

  task automatic push(input logic [15:0] w, input string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic push_gamma(input string t);
    for (int g = 0; g < 3; g++) begin
      int hv = 0;
      for (int k = 0; k < 4; k++) hv += (gm[g*4+k] / 256) * (1 << (6 - 2*k));
      push(bframe(17 + g, hv), t);
    end
    for (int i = 0; i < 12; i++) push(bframe(20 + i, gm[i] % 256), t);
  endtask

  task automatic push_on(input string t);
    push(bframe(2, 8 + b_mode), t);
    push(bframe(3, 223), t);
    push(bframe(32, 240), t);
    push(bframe(33, 240), t);
    push(bframe(4, bmirror(b_h, b_v)), t);
    push_gamma(t);
  endtask

  task automatic push_off(input string t);
    push(bframe(3, 216), t);
    push(bframe(3, 208), t);
  endtask

  task automatic pulse_on();  pwr_on_req = 1;  @(negedge clk); pwr_on_req = 0;  endtask
  task automatic pulse_off(); pwr_off_req = 1; @(negedge clk); pwr_off_req = 0; endtask
  task automatic pulse_apply(); gamma_apply = 1; @(negedge clk); gamma_apply = 0; endtask
  task automatic req_mode(input int m);
    mode_val = 4'(m); mode_req = 1; @(negedge clk); mode_req = 0;
  endtask
  task automatic req_mirror(input bit h, input bit v);
    mirror_h = h; mirror_v = v; mirror_req = 1; @(negedge clk); mirror_req = 0;
  endtask
  task automatic gwrite(input int i, input int val);
    gamma_idx = 4'(i); gamma_val = 10'(val); gamma_wr = 1; @(negedge clk); gamma_wr = 0;
  endtask
  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: decodes frames and timing on the falling clock edge
  logic prev_sclk = 0, prev_cs = 1, prev_sup = 0, prev_rst = 0;
  logic [15:0] sh;
  int nb = 0, t_sup = 0, t_rf = 0;
  bit arm_dn = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(spi_cs_n && spi_sclk), "R12 sclk idle", spi_sclk, 0);
      if (spi_sclk && !prev_sclk && !spi_cs_n) begin
        sh = {sh[14:0], spi_mosi};
        nb++;
      end
      if (!spi_cs_n && prev_cs) begin
        nb = 0;
        if (arm_dn) begin
          chk((cyc - t_rf) >= DN_N && (cyc - t_rf) <= DN_N + 3, "R7 standby wait", cyc - t_rf, DN_N);
          arm_dn = 0;
        end else begin
          chk(panel_rst_n, "R3 frame before reset release", panel_rst_n, 1);
        end
      end
      if (spi_cs_n && !prev_cs) begin
        chk(nb == 16, "R12 sclk edges", nb, 16);
        chk(sh[9:8] == 2'b01, "R1 frame marker", sh, 16'h0100);
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected frame", sh, 0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(sh == e, t, sh, e);
        end
      end
      if (supply_en && !prev_sup) t_sup = cyc;
      if (panel_rst_n && !prev_rst)
        chk((cyc - t_sup) >= UP_N && (cyc - t_sup) <= UP_N + 2, "R3 settle time", cyc - t_sup, UP_N);
      if (!panel_rst_n && prev_rst) begin
        t_rf = cyc;
        arm_dn = 1;
      end
    end
    prev_sclk = spi_sclk;
    prev_cs   = spi_cs_n;
    prev_sup  = supply_en;
    prev_rst  = panel_rst_n;
  end

  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    pwr_on_req = 0; pwr_off_req = 0; mode_req = 0; mode_val = 0; mirror_req = 0;
    mirror_h = 0; mirror_v = 0; gamma_wr = 0; gamma_idx = 0; gamma_val = 0; gamma_apply = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state
    chk(!supply_en, "R2 supply_en", supply_en, 0);
    chk(!panel_rst_n, "R2 panel_rst_n", panel_rst_n, 0);
    chk(spi_cs_n, "R2 spi_cs_n", spi_cs_n, 1);
    chk(!spi_sclk, "R2 spi_sclk", spi_sclk, 0);
    chk(!busy, "R2 busy", busy, 0);
    chk(!powered, "R2 powered", powered, 0);

    // R8 power-down while unpowered does nothing
    pulse_off();
    repeat (30) @(negedge clk);
    chk(!busy && !supply_en && !panel_rst_n, "R8 off ignored", {busy, supply_en, panel_rst_n}, 0);

    // R2/R4/R6 first power-up with defaults (mode 7, no mirror, default gamma)
    push_on("R4 power-up script (R2 default mode, R6 default gamma)");
    pulse_on();
    wait_idle();
    chk(powered && supply_en && panel_rst_n, "R4 powered after script", {powered, supply_en, panel_rst_n}, 7);

    // R8 second power-up ignored
    pulse_on();
    repeat (30) @(negedge clk);
    chk(powered && !busy, "R8 on ignored", {powered, busy}, 2);

    // R9 mode change, then rejected mode
    b_mode = 3;
    push(bframe(2, 8 + 3), "R9 mode write");
    req_mode(3);
    wait_idle();
    req_mode(9);
    repeat (30) @(negedge clk);
    chk(!busy, "R9 invalid mode no job", busy, 0);

    // R5/R10 mirror updates
    b_h = 1; b_v = 0;
    push(bframe(4, bmirror(1, 0)), "R5 mirror h");
    req_mirror(1, 0);
    wait_idle();
    b_h = 1; b_v = 1;
    push(bframe(4, bmirror(1, 1)), "R5 mirror hv");
    req_mirror(1, 1);
    wait_idle();

    // R6/R10 gamma rewrite with an out-of-range index write
    gwrite(2, 767);  gm[2] = 767;
    gwrite(11, 0);   gm[11] = 0;
    gwrite(13, 500);
    push_gamma("R10 gamma rewrite");
    pulse_apply();
    wait_idle();

    // R11 power-down outranks a pending mirror; mirror dropped once unpowered
    push_gamma("R11 running gamma job");
    pulse_apply();
    repeat (10) @(negedge clk);
    req_mirror(0, 1);
    b_h = 0; b_v = 1;
    pulse_off();
    push_off("R7 power-down frames (R11 priority)");
    wait_idle();
    chk(!powered && !supply_en && !panel_rst_n, "R7 unpowered after down", {powered, supply_en, panel_rst_n}, 0);

    // R9/R13 power-up shows kept mode 3 and stored mirror
    push_on("R9 kept mode, R13 stored mirror");
    pulse_on();
    wait_idle();
    push_off("R7 power-down");
    pulse_off();
    wait_idle();

    // R13 mode stored while unpowered, used at next power-up
    req_mode(6);
    b_mode = 6;
    repeat (30) @(negedge clk);
    chk(!busy && !supply_en, "R13 no job when unpowered", {busy, supply_en}, 0);
    push_on("R13 power-up with stored mode");
    pulse_on();
    wait_idle();

    // R11 request during a running job is serviced afterwards
    push_gamma("R11 running gamma job");
    pulse_apply();
    repeat (5) @(negedge clk);
    chk(busy, "R11 busy during job", busy, 1);
    req_mode(2);
    b_mode = 2;
    push(bframe(2, 8 + 2), "R11 pending mode serviced");
    wait_idle();
    chk(!busy, "R11 busy drops after last frame", busy, 0);

    push_off("R7 final power-down");
    pulse_off();
    wait_idle();

    chk(exp_q.size() == 0, "R10 frames outstanding", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule